// File: doc/BRIEF.md
# System Management Command Processor

This block sits on a host bus and takes one-byte commands that switch the subsystems of a multi-processor system on and off. It drives enable lines for a main CPU, a secondary CPU, a sound CPU and an optical-drive subsystem. It also drives a whole-system reset, a main-CPU restart hold, a clock-mode select, a one-shot NMI request, and an enable for NMI generation from the reset button.

The host writes a code into the command register. While a command runs, a busy flag is raised, and writes that arrive during that time are dropped. This lets software avoid issuing a command twice. Every command has a busy time set by its class:

- CPU, sound and control commands use a short time.
- Drive commands use a somewhat longer time.
- System reset and the clock changes use a long time.

All busy times are derived from a clocks-per-microsecond parameter. When a command finishes, its effect is applied to the outputs and its code is copied into the result register. The busy flag drops on that same clock edge. No command takes input parameters or raises an interrupt.

Top module: `sysmgmt_cmd_proc`

## Requirements
- R1: While reset (rst_n low) is held through a rising clock edge, the outputs take these values: busy=0, result=00h, main_en=1, sec_en=0, snd_en=0, drv_en=0, clk_sel=0, btn_nmi_en=1, nmi_req=0, sys_rst=0 and main_rst=0.
- R2: When cmd_wr is sampled high while busy is low, busy is high from the next cycle on. While busy is low, main_rst and sys_rst stay low.
- R3: A write sampled while busy is high is ignored. It does not change the busy time, the final result or any output.
- R4: busy stays high for exactly N cycles, where N = T×CLK_PER_US and T is chosen as follows:
  - T = T_CPU_US for codes 00h, 02h, 03h, 06h, 07h, 18h, 19h and 1Ah, and for any undefined code.
  - T = T_DRV_US for codes 08h and 09h.
  - T = T_LONG_US for codes 0Dh, 0Eh and 0Fh.
- R5: result changes only on the edge where busy falls. After that edge it holds the code that was executed.
- R6: The enable outputs change only on the edge where busy falls:
  - 00h sets main_en.
  - 02h sets sec_en and 03h clears it.
  - 06h sets snd_en and 07h clears it.
  - 08h sets drv_en and 09h clears it.
- R7: Code 0Dh holds sys_rst and main_rst high for the whole busy time. When it completes, main_en, sec_en, snd_en, drv_en and btn_nmi_en return to their R1 values, and clk_sel is kept.
- R8: Code 0Eh sets clk_sel to 1 (mode 352) and code 0Fh sets it to 0 (mode 320). Both hold main_rst high while busy, and both leave sec_en at 0 when they complete.
- R9: Code 18h produces nmi_req high for exactly the one cycle after the edge where busy falls. btn_nmi_en has no effect on this.
- R10: Code 19h sets btn_nmi_en and code 1Ah clears it.
- R11: An undefined code runs for the short busy time and changes no enable, clk_sel or btn_nmi_en output. result still echoes the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command code |
| busy | output | 1 | Command-in-progress flag |
| result | output | 8 | Code of the last completed command |
| main_en | output | 1 | Main CPU enable |
| sec_en | output | 1 | Secondary CPU enable |
| snd_en | output | 1 | Sound CPU enable |
| drv_en | output | 1 | Optical drive enable |
| clk_sel | output | 1 | Clock mode, 1 = 352, 0 = 320 |
| btn_nmi_en | output | 1 | Reset-button NMI enable |
| nmi_req | output | 1 | One-cycle NMI request to the main CPU |
| sys_rst | output | 1 | Whole-system reset, high while 0Dh runs |
| main_rst | output | 1 | Main CPU restart hold during reset and clock change |

## Verification
Each result has a fixed due cycle:

- busy rises on the cycle after the accepting edge.
- result, the enables, clk_sel and btn_nmi_en all change exactly N edges after acceptance, on the same edge where busy falls.
- nmi_req is high only for the cycle that follows that edge.

The bench holds a behavioural model that counts the busy cycles for each code. It advances the model on every rising edge and compares every output with the model on the following falling edge, so a result that arrives one cycle early or late shows up as a mismatch. Directed checks cover the reset values, a write dropped while busy, and an undefined code.

// File: rtl/sysmgmt_pkg.sv
// Shared types for the system management command processor.
// Assumes command codes are one byte and that each command falls into one of three busy classes.
package sysmgmt_pkg;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_MAIN_ON,
        ACT_SEC_ON,
        ACT_SEC_OFF,
        ACT_SND_ON,
        ACT_SND_OFF,
        ACT_DRV_ON,
        ACT_DRV_OFF,
        ACT_SYS_RESET,
        ACT_CLK_352,
        ACT_CLK_320,
        ACT_NMI,
        ACT_BTN_ENABLE,
        ACT_BTN_DISABLE
    } act_e;

    typedef enum logic [1:0] {
        DUR_SHORT,
        DUR_DRIVE,
        DUR_LONG
    } dur_e;

    typedef struct packed {
        act_e act;
        dur_e dur;
    } cmd_info_t;

    typedef struct packed {
        logic main_on;
        logic sec_on;
        logic snd_on;
        logic drv_on;
        logic clk352;
        logic btn_nmi;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '{main_on: 1'b1, sec_on: 1'b0, snd_on: 1'b0,
                                     drv_on: 1'b0, clk352: 1'b0, btn_nmi: 1'b1};

    localparam logic [7:0] OP_MAIN_ON  = 8'h00;
    localparam logic [7:0] OP_SEC_ON   = 8'h02;
    localparam logic [7:0] OP_SEC_OFF  = 8'h03;
    localparam logic [7:0] OP_SND_ON   = 8'h06;
    localparam logic [7:0] OP_SND_OFF  = 8'h07;
    localparam logic [7:0] OP_DRV_ON   = 8'h08;
    localparam logic [7:0] OP_DRV_OFF  = 8'h09;
    localparam logic [7:0] OP_SYS_RST  = 8'h0D;
    localparam logic [7:0] OP_CLK_352  = 8'h0E;
    localparam logic [7:0] OP_CLK_320  = 8'h0F;
    localparam logic [7:0] OP_NMI      = 8'h18;
    localparam logic [7:0] OP_BTN_EN   = 8'h19;
    localparam logic [7:0] OP_BTN_DIS  = 8'h1A;

endpackage

// File: rtl/sysmgmt_decode.sv
// Command decoder: maps a one-byte code to an action and a busy class.
// Purely combinational. An undefined code yields ACT_NONE with the short class.
module sysmgmt_decode
    import sysmgmt_pkg::*;
(
    input  logic [7:0] code,
    output cmd_info_t  info
);

    // Look up the action and busy class for the code.
    always_comb begin
        info = '{act: ACT_NONE, dur: DUR_SHORT};
        unique case (code)
            OP_MAIN_ON: info.act = ACT_MAIN_ON;
            OP_SEC_ON:  info.act = ACT_SEC_ON;
            OP_SEC_OFF: info.act = ACT_SEC_OFF;
            OP_SND_ON:  info.act = ACT_SND_ON;
            OP_SND_OFF: info.act = ACT_SND_OFF;
            OP_DRV_ON:  info = '{act: ACT_DRV_ON,    dur: DUR_DRIVE};
            OP_DRV_OFF: info = '{act: ACT_DRV_OFF,   dur: DUR_DRIVE};
            OP_SYS_RST: info = '{act: ACT_SYS_RESET, dur: DUR_LONG};
            OP_CLK_352: info = '{act: ACT_CLK_352,   dur: DUR_LONG};
            OP_CLK_320: info = '{act: ACT_CLK_320,   dur: DUR_LONG};
            OP_NMI:     info.act = ACT_NMI;
            OP_BTN_EN:  info.act = ACT_BTN_ENABLE;
            OP_BTN_DIS: info.act = ACT_BTN_DISABLE;
            default:    info = '{act: ACT_NONE, dur: DUR_SHORT};
        endcase
    end

endmodule

// File: rtl/sysmgmt_timer.sv
// Busy timer: on start it loads the cycle count for the class and holds busy for exactly that many cycles.
// done is high in the last busy cycle, and busy falls on the edge that follows it.
// Assumes every cycle count is at least 1 and that start is only raised while idle.
module sysmgmt_timer
    import sysmgmt_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 3000,
    parameter int unsigned DRIVE_CYC = 4000,
    parameter int unsigned LONG_CYC  = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  dur_e dur,
    output logic busy,
    output logic done
);

    localparam int unsigned MAX_CYC = (LONG_CYC > DRIVE_CYC) ?
        ((LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC) :
        ((DRIVE_CYC > SHORT_CYC) ? DRIVE_CYC : SHORT_CYC);
    localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;

    // Select the reload value, one less than the class length.
    always_comb begin
        unique case (dur)
            DUR_DRIVE: load_val = CNT_W'(DRIVE_CYC - 1);
            DUR_LONG:  load_val = CNT_W'(LONG_CYC - 1);
            default:   load_val = CNT_W'(SHORT_CYC - 1);
        endcase
    end

    assign done = busy && (remain_q == '0);

    // Count down the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            remain_q <= load_val;
        end else if (done) begin
            busy     <= 1'b0;
        end else if (busy) begin
            remain_q <= remain_q - 1'b1;
        end
    end

endmodule

// File: rtl/sysmgmt_ctl.sv
// Output control: holds the subsystem enables and applies each action on completion.
// Drives the reset holds during long commands and a one-cycle NMI pulse.
// Assumes start and done are never high together.
module sysmgmt_ctl
    import sysmgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  act_e start_act,
    input  logic done,
    input  act_e run_act,
    output ctl_t ctl,
    output logic sys_rst,
    output logic main_rst,
    output logic nmi_req
);

    // Apply the finished action to the enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= CTL_DEFAULT;
        end else if (done) begin
            unique case (run_act)
                ACT_MAIN_ON:     ctl.main_on <= 1'b1;
                ACT_SEC_ON:      ctl.sec_on  <= 1'b1;
                ACT_SEC_OFF:     ctl.sec_on  <= 1'b0;
                ACT_SND_ON:      ctl.snd_on  <= 1'b1;
                ACT_SND_OFF:     ctl.snd_on  <= 1'b0;
                ACT_DRV_ON:      ctl.drv_on  <= 1'b1;
                ACT_DRV_OFF:     ctl.drv_on  <= 1'b0;
                ACT_SYS_RESET:   ctl <= '{main_on: CTL_DEFAULT.main_on, sec_on: CTL_DEFAULT.sec_on,
                                         snd_on: CTL_DEFAULT.snd_on, drv_on: CTL_DEFAULT.drv_on,
                                         clk352: ctl.clk352, btn_nmi: CTL_DEFAULT.btn_nmi};
                ACT_CLK_352: begin
                    ctl.clk352 <= 1'b1;
                    ctl.sec_on <= 1'b0;
                end
                ACT_CLK_320: begin
                    ctl.clk352 <= 1'b0;
                    ctl.sec_on <= 1'b0;
                end
                ACT_BTN_ENABLE:  ctl.btn_nmi <= 1'b1;
                ACT_BTN_DISABLE: ctl.btn_nmi <= 1'b0;
                default:         ctl <= ctl;
            endcase
        end
    end

    // Hold the reset lines for the length of a reset or clock-change command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst  <= 1'b0;
            main_rst <= 1'b0;
        end else if (start) begin
            sys_rst  <= (start_act == ACT_SYS_RESET);
            main_rst <= (start_act == ACT_SYS_RESET) || (start_act == ACT_CLK_352) ||
                        (start_act == ACT_CLK_320);
        end else if (done) begin
            sys_rst  <= 1'b0;
            main_rst <= 1'b0;
        end
    end

    // Raise the NMI request for one cycle when the NMI command finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= done && (run_act == ACT_NMI);
    end

endmodule

// File: rtl/sysmgmt_cmd_proc.sv
// System management command processor, top level.
// Accepts a command code while idle, times its busy window, applies it and echoes the code to result.
// Assumes cmd_data is valid whenever cmd_wr is high. Writes made while busy are dropped.
module sysmgmt_cmd_proc
    import sysmgmt_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned T_CPU_US   = 30,
    parameter int unsigned T_DRV_US   = 40,
    parameter int unsigned T_LONG_US  = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    output logic       busy,
    output logic [7:0] result,
    output logic       main_en,
    output logic       sec_en,
    output logic       snd_en,
    output logic       drv_en,
    output logic       clk_sel,
    output logic       btn_nmi_en,
    output logic       nmi_req,
    output logic       sys_rst,
    output logic       main_rst
);

    localparam int unsigned SHORT_CYC = T_CPU_US  * CLK_PER_US;
    localparam int unsigned DRIVE_CYC = T_DRV_US  * CLK_PER_US;
    localparam int unsigned LONG_CYC  = T_LONG_US * CLK_PER_US;

    cmd_info_t  dec_info;
    logic       start;
    logic       done;
    logic [7:0] code_q;
    act_e       act_q;
    ctl_t       ctl;

    assign start = cmd_wr && !busy;

    sysmgmt_decode u_decode (
        .code (cmd_data),
        .info (dec_info)
    );

    sysmgmt_timer #(
        .SHORT_CYC (SHORT_CYC),
        .DRIVE_CYC (DRIVE_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .dur   (dec_info.dur),
        .busy  (busy),
        .done  (done)
    );

    // Latch the accepted code and action for the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            act_q  <= ACT_NONE;
        end else if (start) begin
            code_q <= cmd_data;
            act_q  <= dec_info.act;
        end
    end

    // Copy the executed code into the result register on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (done) result <= code_q;
    end

    sysmgmt_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_act (dec_info.act),
        .done      (done),
        .run_act   (act_q),
        .ctl       (ctl),
        .sys_rst   (sys_rst),
        .main_rst  (main_rst),
        .nmi_req   (nmi_req)
    );

    assign main_en    = ctl.main_on;
    assign sec_en     = ctl.sec_on;
    assign snd_en     = ctl.snd_on;
    assign drv_en     = ctl.drv_on;
    assign clk_sel    = ctl.clk352;
    assign btn_nmi_en = ctl.btn_nmi;

endmodule

// File: rtl/sysmgmt_cmd_proc_chk.sv
// Property checker for sysmgmt_cmd_proc, attached through bind.
// Assumes reset is held low for at least one clock edge at start-up.
module sysmgmt_cmd_proc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       busy,
    input logic [7:0] result,
    input logic       main_en,
    input logic       sec_en,
    input logic       snd_en,
    input logic       drv_en,
    input logic       clk_sel,
    input logic       btn_nmi_en,
    input logic       nmi_req,
    input logic       sys_rst,
    input logic       main_rst
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !busy |=> busy);

    assert_idle_no_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !main_rst && !sys_rst);

    assert_result_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));

    assert_enables_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable({main_en, sec_en, snd_en, drv_en, clk_sel, btn_nmi_en}));

    assert_sysrst_with_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> busy && main_rst);

    assert_clk_change_sec_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(clk_sel) |-> !sec_en);

    assert_nmi_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $fell(busy));

    assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

endmodule

bind sysmgmt_cmd_proc sysmgmt_cmd_proc_chk u_chk (.*);

// File: tb/sysmgmt_cmd_proc_test.sv
// Bench: a behavioural reference model, advanced on each rising edge and compared on each falling edge.
module sysmgmt_cmd_proc_test;

    localparam int CPU_US = 2;
    localparam int SHORT  = 30 * CPU_US;
    localparam int DRIVE  = 40 * CPU_US;
    localparam int LONGC  = 200 * CPU_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       busy, main_en, sec_en, snd_en, drv_en, clk_sel, btn_nmi_en, nmi_req, sys_rst, main_rst;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int   m_rem = 0;
    int   m_code = 0;
    int   m_result = 0;
    bit   m_main = 1, m_sec = 0, m_snd = 0, m_drv = 0, m_clk = 0, m_btn = 1, m_nmi = 0;
    bit   m_sysr = 0, m_mainr = 0;
    bit   cmp_on = 0;

    always #5 clk = ~clk;

    sysmgmt_cmd_proc #(
        .CLK_PER_US (CPU_US),
        .T_CPU_US   (30),
        .T_DRV_US   (40),
        .T_LONG_US  (200)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .busy(busy), .result(result), .main_en(main_en), .sec_en(sec_en),
        .snd_en(snd_en), .drv_en(drv_en), .clk_sel(clk_sel), .btn_nmi_en(btn_nmi_en),
        .nmi_req(nmi_req), .sys_rst(sys_rst), .main_rst(main_rst)
    );

    function automatic int busy_len(int code);
        case (code)
            8'h08, 8'h09:        return DRIVE;
            8'h0D, 8'h0E, 8'h0F: return LONGC;
            default:             return SHORT;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model: advance one clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_code = 0; m_result = 0;
            m_main = 1; m_sec = 0; m_snd = 0; m_drv = 0; m_clk = 0; m_btn = 1;
            m_nmi = 0; m_sysr = 0; m_mainr = 0;
        end else begin
            m_nmi = 0;
            if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_result = m_code;
                    m_sysr = 0; m_mainr = 0;
                    case (m_code)
                        8'h00: m_main = 1;
                        8'h02: m_sec = 1;
                        8'h03: m_sec = 0;
                        8'h06: m_snd = 1;
                        8'h07: m_snd = 0;
                        8'h08: m_drv = 1;
                        8'h09: m_drv = 0;
                        8'h0D: begin m_main = 1; m_sec = 0; m_snd = 0; m_drv = 0; m_btn = 1; end
                        8'h0E: begin m_clk = 1; m_sec = 0; end
                        8'h0F: begin m_clk = 0; m_sec = 0; end
                        8'h18: m_nmi = 1;
                        8'h19: m_btn = 1;
                        8'h1A: m_btn = 0;
                        default: ;
                    endcase
                end
            end else if (cmd_wr) begin
                m_code = cmd_data;
                m_rem = busy_len(cmd_data);
                m_sysr = (cmd_data == 8'h0D);
                m_mainr = (cmd_data == 8'h0D) || (cmd_data == 8'h0E) || (cmd_data == 8'h0F);
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("R4", "busy", busy, m_rem > 0);
            chk("R5", "result", result, m_result);
            chk("R6", "main_en", main_en, m_main);
            chk("R6", "sec_en", sec_en, m_sec);
            chk("R6", "snd_en", snd_en, m_snd);
            chk("R6", "drv_en", drv_en, m_drv);
            chk("R8", "clk_sel", clk_sel, m_clk);
            chk("R10", "btn_nmi_en", btn_nmi_en, m_btn);
            chk("R9", "nmi_req", nmi_req, m_nmi);
            chk("R7", "sys_rst", sys_rst, m_sysr);
            chk("R7", "main_rst", main_rst, m_mainr);
        end
    end

    task automatic issue(int code);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_data = 8'(code);
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_rem > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(int code);
        issue(code);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held under reset
        chk("R1", "busy", busy, 0);
        chk("R1", "result", result, 0);
        chk("R1", "enables", {main_en, sec_en, snd_en, drv_en}, 4'b1000);
        chk("R1", "clk_sel", clk_sel, 0);
        chk("R1", "btn_nmi_en", btn_nmi_en, 1);
        chk("R1", "pulses", {nmi_req, sys_rst, main_rst}, 0);
        rst_n = 1'b1;
        cmp_on = 1;

        issue(8'h02);
        chk("R2", "busy after accept", busy, 1);
        wait_idle();
        run(8'h06);
        run(8'h08);
        run(8'h18);
        run(8'h1A);
        run(8'h18);
        run(8'h19);
        run(8'h07);
        run(8'h09);
        run(8'h00);

        // R3: a second write during busy is dropped
        issue(8'h06);
        repeat (5) @(negedge clk);
        issue(8'h07);
        wait_idle();
        chk("R3", "snd_en kept", snd_en, 1);
        chk("R3", "result kept", result, 8'h06);

        // R8 clock changes with the secondary CPU running
        run(8'h02);
        run(8'h0E);
        chk("R8", "sec off after 352", sec_en, 0);
        run(8'h02);
        run(8'h0F);
        chk("R8", "clk 320", clk_sel, 0);

        // R7 full reset after changing state
        run(8'h0E);
        run(8'h08);
        run(8'h1A);
        run(8'h0D);
        chk("R7", "drv default", drv_en, 0);
        chk("R7", "clk kept", clk_sel, 1);

        // R11 undefined codes
        run(8'h06);
        run(8'h55);
        chk("R11", "result echo", result, 8'h55);
        chk("R11", "snd unchanged", snd_en, 1);
        run(8'hFF);
        run(8'h01);
        chk("R11", "main unchanged", main_en, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule